// File: doc/BRIEF.md
# Slice-Serial Wide Adder

This block adds two wide operands (128 bits by default) over a narrow datapath, so that only one slice of each operand is on the pins at a time. The caller presents the operand slices least significant first, one pair per transfer. It raises a start flag together with the first pair. Only one slice-wide adder exists. The carry out of each slice is held in a register and feeds the next slice, so the combinational depth is that of a slice-wide adder and not a full-width one.

Every accepted slice pair yields one result slice, which appears in the cycle after acceptance and is also least significant first. Result slices leave through a valid/ready pair. When the last result slice is presented, a completion flag and the final carry out are raised alongside it. While a result slice waits for the consumer, the block refuses further input. A start flag that arrives while an addition is in progress has no effect.

Top module: `wide_slice_adder`

## Requirements
- R1: While idle, the block accepts a slice pair only when start_i is high. With start_i low while idle, in_ready_o is 0, and an offered slice produces no output.
- R2: The first slice of an addition is added with a carry in of 0, whatever carry the previous addition left.
- R3: Each later slice is added with the carry out of the previous slice of the same addition. Carries therefore ripple correctly across slice boundaries.
- R4: A slice pair is accepted in a cycle where in_valid_i and in_ready_o are both high. Its result slice (a_slice + b_slice + carry in, low SLICE_W bits) is on sum_slice_o with out_valid_o high from the next clock edge. Result slices come out in acceptance order, least significant first.
- R5: done_o and the final carry are asserted only while the last (TOTAL_W/SLICE_W-th) result slice of an addition is presented. carry_out_o is 0 with every other result slice.
- R6: While out_valid_o is high and out_ready_i is low, in_ready_o is 0. Over that time sum_slice_o, carry_out_o, done_o and out_valid_o hold their values.
- R7: start_i asserted while an addition is in progress is ignored. It clears no carry and does not restart the slice count.
- R8: Asserting rst_n low (asynchronous, active low) returns the block to idle at once: out_valid_o, done_o and carry_out_o are 0, and the held carry is cleared. Release takes effect after two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Marks the first slice pair of a new addition |
| in_valid_i | input | 1 | Slice pair on a_slice_i/b_slice_i is valid |
| in_ready_o | output | 1 | Block can take a slice pair this cycle |
| a_slice_i | input | SLICE_W | Slice of the first operand |
| b_slice_i | input | SLICE_W | Slice of the second operand |
| out_valid_o | output | 1 | Result slice is valid |
| out_ready_i | input | 1 | Consumer takes the result slice this cycle |
| sum_slice_o | output | SLICE_W | Result slice |
| carry_out_o | output | 1 | Final carry of the addition, valid with done_o, else 0 |
| done_o | output | 1 | Last result slice of the addition is presented |

## Verification
The assertions assume that the consumer samples a result slice only when out_valid_o is high. They also assume that a caller offering a slice pair keeps in_valid_i and the slice data steady until in_ready_o admits it. They do not assume that start_i is clean: it may be raised on any slice. The stimulus changes inputs only on the falling clock edge, and it holds each slice pair through a stall until it is admitted. It deliberately raises start_i in the middle of an addition and offers slices while idle without start, so that the ignore rules of R1 and R7 are exercised and not merely avoided.

// File: rtl/wsa_pkg.sv
package wsa_pkg;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_BUSY = 1'b1
  } seq_state_e;

endpackage

// File: rtl/wsa_slice_core.sv
module wsa_slice_core #(
  parameter int  SLICE_W = 32,
  parameter bit  RIPPLE  = 1'b0
) (
  input  logic [SLICE_W-1:0] a_i,
  input  logic [SLICE_W-1:0] b_i,
  input  logic               cin_i,
  output logic [SLICE_W-1:0] sum_o,
  output logic               cout_o
);

  generate
    if (RIPPLE) begin : g_ripple
      logic [SLICE_W:0] chain;
      assign chain[0] = cin_i;
      for (genvar i = 0; i < SLICE_W; i++) begin : g_bit
        logic half;
        assign half        = a_i[i] ^ b_i[i];
        assign sum_o[i]    = half ^ chain[i];
        assign chain[i+1]  = (a_i[i] & b_i[i]) | (half & chain[i]);
      end
      assign cout_o = chain[SLICE_W];
    end else begin : g_behav
      logic [SLICE_W:0] wide;
      assign wide   = {1'b0, a_i} + {1'b0, b_i} + {{SLICE_W{1'b0}}, cin_i};
      assign sum_o  = wide[SLICE_W-1:0];
      assign cout_o = wide[SLICE_W];
    end
  endgenerate

endmodule

// File: rtl/wsa_seq_ctrl.sv
module wsa_seq_ctrl
  import wsa_pkg::*;
#(
  parameter int NUM_SLICES = 4,
  localparam int CNT_W = (NUM_SLICES > 1) ? $clog2(NUM_SLICES) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic in_valid_i,
  input  logic stall_i,
  input  logic core_cout_i,
  output logic in_ready_o,
  output logic accept_o,
  output logic cin_o,
  output logic last_o
);

  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(NUM_SLICES - 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             carry_q, carry_d;
  logic [CNT_W-1:0] cur_idx;
  logic             first;

  assign first      = (state_q == SEQ_IDLE);
  assign cur_idx    = first ? '0 : cnt_q;
  assign in_ready_o = !stall_i && (!first || start_i);
  assign accept_o   = in_valid_i && in_ready_o;
  assign cin_o      = first ? 1'b0 : carry_q;
  assign last_o     = (cur_idx == LAST_IDX);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    carry_d = carry_q;
    if (accept_o) begin
      if (last_o) begin
        state_d = SEQ_IDLE;
        cnt_d   = '0;
        carry_d = 1'b0;
      end else begin
        state_d = SEQ_BUSY;
        cnt_d   = cur_idx + CNT_W'(1);
        carry_d = core_cout_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      carry_q <= 1'b0;
    end else if (accept_o) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      carry_q <= carry_d;
    end
  end

  // R3: held carry follows the slice carry-out between slices
  assert_carry_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_o && !last_o) |=> (carry_q == $past(core_cout_i)));

  // R7: a busy accept advances the count by one even when start is high
  assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!first && accept_o && !last_o) |=> (!first && cnt_q == $past(cnt_q) + CNT_W'(1)));

  // R2: an addition that ends leaves the block idle with no carry held
  assert_idle_after_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_o && last_o) |=> (first && !carry_q));

endmodule

// File: rtl/wsa_out_stage.sv
module wsa_out_stage #(
  parameter int SLICE_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [SLICE_W-1:0] sum_i,
  input  logic               cout_i,
  input  logic               last_i,
  input  logic               out_ready_i,
  output logic               out_valid_o,
  output logic [SLICE_W-1:0] sum_o,
  output logic               carry_o,
  output logic               done_o,
  output logic               stall_o
);

  logic               valid_q, valid_d;
  logic [SLICE_W-1:0] sum_q, sum_d;
  logic               carry_q, carry_d;
  logic               last_q, last_d;
  logic               en;

  assign en = load_i || out_ready_i;

  always_comb begin
    valid_d = valid_q;
    sum_d   = sum_q;
    carry_d = carry_q;
    last_d  = last_q;
    if (load_i) begin
      valid_d = 1'b1;
      sum_d   = sum_i;
      carry_d = last_i & cout_i;
      last_d  = last_i;
    end else if (out_ready_i) begin
      valid_d = 1'b0;
      carry_d = 1'b0;
      last_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      sum_q   <= '0;
      carry_q <= 1'b0;
      last_q  <= 1'b0;
    end else if (en) begin
      valid_q <= valid_d;
      sum_q   <= sum_d;
      carry_q <= carry_d;
      last_q  <= last_d;
    end
  end

  assign out_valid_o = valid_q;
  assign sum_o       = sum_q;
  assign carry_o     = carry_q;
  assign done_o      = valid_q && last_q;
  assign stall_o     = valid_q && !out_ready_i;

  // R6: a stalled result slice stays put
  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !out_ready_i) |=> (valid_q && $stable(sum_q) && $stable(carry_q) && $stable(last_q)));

endmodule

// File: rtl/wide_slice_adder.sv
module wide_slice_adder #(
  parameter int TOTAL_W = 128,
  parameter int SLICE_W = 32,
  parameter bit RIPPLE  = 1'b0,
  localparam int NUM_SLICES = TOTAL_W / SLICE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               in_valid_i,
  output logic               in_ready_o,
  input  logic [SLICE_W-1:0] a_slice_i,
  input  logic [SLICE_W-1:0] b_slice_i,
  output logic               out_valid_o,
  input  logic               out_ready_i,
  output logic [SLICE_W-1:0] sum_slice_o,
  output logic               carry_out_o,
  output logic               done_o
);

  logic [1:0]         rst_sync_q;
  logic               rst_int_n;
  logic               accept;
  logic               cin;
  logic               last;
  logic               stall;
  logic [SLICE_W-1:0] core_sum;
  logic               core_cout;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  wsa_seq_ctrl #(.NUM_SLICES(NUM_SLICES)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .start_i     (start_i),
    .in_valid_i  (in_valid_i),
    .stall_i     (stall),
    .core_cout_i (core_cout),
    .in_ready_o  (in_ready_o),
    .accept_o    (accept),
    .cin_o       (cin),
    .last_o      (last)
  );

  wsa_slice_core #(.SLICE_W(SLICE_W), .RIPPLE(RIPPLE)) u_core (
    .a_i    (a_slice_i),
    .b_i    (b_slice_i),
    .cin_i  (cin),
    .sum_o  (core_sum),
    .cout_o (core_cout)
  );

  wsa_out_stage #(.SLICE_W(SLICE_W)) u_out (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .load_i      (accept),
    .sum_i       (core_sum),
    .cout_i      (core_cout),
    .last_i      (last),
    .out_ready_i (out_ready_i),
    .out_valid_o (out_valid_o),
    .sum_o       (sum_slice_o),
    .carry_o     (carry_out_o),
    .done_o      (done_o),
    .stall_o     (stall)
  );

  // R4: an accepted slice is presented from the next edge
  assert_result_next_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    accept |=> out_valid_o);

  // R6: no input is admitted while a result slice waits
  assert_no_admit_stalled_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (out_valid_o && !out_ready_i) |-> !in_ready_o);

  // R5: carry output is quiet except with the final slice
  assert_carry_quiet_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (out_valid_o && !done_o) |-> !carry_out_o);

  // R1: while idle with no start nothing reaches the output
  assert_idle_needs_start_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid_i && !start_i && !out_valid_o && u_ctrl.state_q == wsa_pkg::SEQ_IDLE) |=> !out_valid_o);

endmodule

// File: tb/wide_slice_adder_tb.sv
module wide_slice_adder_tb;

  localparam int TOTAL_W = 128;
  localparam int SLICE_W = 32;
  localparam int NS      = TOTAL_W / SLICE_W;
  localparam int NVEC    = 6;

  localparam logic [TOTAL_W-1:0] VA [NVEC] = '{
    128'h0,
    {128{1'b1}},
    {64'h0, {64{1'b1}}},
    {32{4'hA}},
    {128{1'b1}},
    128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210
  };
  localparam logic [TOTAL_W-1:0] VB [NVEC] = '{
    128'h0,
    128'h1,
    {{64{1'b1}}, 64'h0},
    {32{4'h5}},
    {128{1'b1}},
    128'h8000_0000_FFFF_FFFF_0000_0001_8000_0000
  };

  logic               clk = 1'b0;
  logic               rst_n;
  logic               start_i;
  logic               in_valid_i;
  logic               in_ready_o;
  logic [SLICE_W-1:0] a_slice_i;
  logic [SLICE_W-1:0] b_slice_i;
  logic               out_valid_o;
  logic               out_ready_i;
  logic [SLICE_W-1:0] sum_slice_o;
  logic               carry_out_o;
  logic               done_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  wide_slice_adder #(.TOTAL_W(TOTAL_W), .SLICE_W(SLICE_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .in_valid_i(in_valid_i),
    .in_ready_o(in_ready_o), .a_slice_i(a_slice_i), .b_slice_i(b_slice_i),
    .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
    .sum_slice_o(sum_slice_o), .carry_out_o(carry_out_o), .done_o(done_o)
  );

  task automatic chk(input string req, input logic [TOTAL_W-1:0] act, input logic [TOTAL_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Full addition with out_ready held high; start also raised on slice mid_start (>0) if given.
  task automatic run_add(input logic [TOTAL_W-1:0] a, input logic [TOTAL_W-1:0] b, input int mid_start);
    logic [TOTAL_W:0] ref_sum;
    ref_sum = {1'b0, a} + {1'b0, b};
    for (int s = 0; s < NS; s++) begin
      @(negedge clk);
      in_valid_i = 1'b1;
      start_i    = (s == 0) || (s == mid_start);
      a_slice_i  = a[s*SLICE_W +: SLICE_W];
      b_slice_i  = b[s*SLICE_W +: SLICE_W];
      @(posedge clk); #1;
      chk("R4 out_valid", {127'b0, out_valid_o}, 128'd1);
      chk(s == 0 ? "R2 first slice sum" : "R3 slice sum", {96'b0, sum_slice_o},
          {96'b0, ref_sum[s*SLICE_W +: SLICE_W]});
      chk("R5 done", {127'b0, done_o}, {127'b0, s == NS-1});
      chk("R5 carry_out", {127'b0, carry_out_o}, {127'b0, (s == NS-1) & ref_sum[TOTAL_W]});
    end
    @(negedge clk);
    in_valid_i = 1'b0;
    start_i    = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [TOTAL_W-1:0] sa, sb;
    logic [TOTAL_W:0]   sref;
    rst_n = 1'b0; start_i = 1'b0; in_valid_i = 1'b0; out_ready_i = 1'b1;
    a_slice_i = '0; b_slice_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk); #1;

    // R8 reset state, R1 idle without start
    chk("R8 out_valid after reset", {127'b0, out_valid_o}, 128'd0);
    chk("R8 done after reset", {127'b0, done_o}, 128'd0);
    chk("R8 carry_out after reset", {127'b0, carry_out_o}, 128'd0);
    chk("R1 in_ready idle no start", {127'b0, in_ready_o}, 128'd0);

    // R1: slice offered while idle without start is not taken
    @(negedge clk);
    in_valid_i = 1'b1; a_slice_i = 32'h1234_5678; b_slice_i = 32'h1;
    @(posedge clk); #1;
    chk("R1 no output without start", {127'b0, out_valid_o}, 128'd0);
    @(negedge clk); in_valid_i = 1'b0;

    // Vector table: R2 R3 R4 R5
    for (int v = 0; v < NVEC; v++) run_add(VA[v], VB[v], -1);

    // R6 stall
    sa = 128'h0000_0004_0000_0003_0000_0002_FFFF_FFFF;
    sb = 128'h1;
    sref = {1'b0, sa} + {1'b0, sb};
    @(negedge clk);
    out_ready_i = 1'b0; in_valid_i = 1'b1; start_i = 1'b1;
    a_slice_i = sa[31:0]; b_slice_i = sb[31:0];
    @(posedge clk); #1;
    chk("R6 first slice", {96'b0, sum_slice_o}, {96'b0, sref[31:0]});
    @(negedge clk);
    start_i = 1'b0; a_slice_i = sa[63:32]; b_slice_i = sb[63:32];
    #1;
    chk("R6 in_ready low while stalled", {127'b0, in_ready_o}, 128'd0);
    @(posedge clk); #1;
    chk("R6 output held", {96'b0, sum_slice_o}, {96'b0, sref[31:0]});
    chk("R6 valid held", {127'b0, out_valid_o}, 128'd1);
    @(negedge clk); out_ready_i = 1'b1;
    @(posedge clk); #1;
    chk("R6 slice after stall", {96'b0, sum_slice_o}, {96'b0, sref[63:32]});
    for (int s = 2; s < NS; s++) begin
      @(negedge clk);
      a_slice_i = sa[s*SLICE_W +: SLICE_W]; b_slice_i = sb[s*SLICE_W +: SLICE_W];
      @(posedge clk); #1;
      chk("R6 remaining slice", {96'b0, sum_slice_o}, {96'b0, sref[s*SLICE_W +: SLICE_W]});
      chk("R6 done", {127'b0, done_o}, {127'b0, s == NS-1});
    end
    @(negedge clk); in_valid_i = 1'b0;

    // R7 start mid-operation ignored
    run_add({128{1'b1}}, 128'h1, 2);
    run_add(128'h0000_0001_FFFF_FFFF_0000_0000_FFFF_FFFF, 128'h0000_0000_0000_0001_0000_0000_0000_0001, 1);

    // R8 reset mid-operation clears held carry
    for (int s = 0; s < 2; s++) begin
      @(negedge clk);
      in_valid_i = 1'b1; start_i = (s == 0);
      a_slice_i = '1; b_slice_i = (s == 0) ? 32'h1 : 32'h0;
      @(posedge clk);
    end
    @(negedge clk);
    in_valid_i = 1'b0; start_i = 1'b0; rst_n = 1'b0;
    #1;
    chk("R8 out_valid in reset", {127'b0, out_valid_o}, 128'd0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    run_add(128'h0, 128'h0, -1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule